// File: doc/BRIEF.md
# Ethernet receive frame filter

This block sits between a byte-wide receive stream and a receive FIFO and decides, frame by frame, whether the frame is kept. Bytes arrive with a valid strobe. Start-of-frame and end-of-frame strobes coincide with the first and last bytes, and a CRC-good flag is sampled with the last byte. The first six bytes form the destination address. They are written to the FIFO speculatively while the block collects them. When the sixth byte arrives, the block compares the address against a 48-bit station address input and applies the broadcast, multicast and promiscuous rules. A kept frame continues to be written and is committed on its last byte. A rejected frame is rolled back with a drop strobe and writes nothing more.

A 32-bit control register, reached over a simple read/write strobe bus, holds the enables and a flush request. A bad CRC, when rejection is enabled, resets the whole FIFO and pulses an error flag. Every FIFO-side output is registered and appears one clock after the input byte that caused it.

Top module: `eth_rx_filter`

## Requirements
- R1: After reset the control register reads 0x00000008. Bits 31:5 always read 0, and writing them has no effect.
- R2: Control bits 3:0 are read/write. Bit 0 is receive enable, bit 1 is accept-all-multicast, bit 2 is promiscuous and bit 3 is reject-bad-CRC. Together they set the acceptance rules in R5 to R10.
- R3: Writing 1 to bit 4 raises `fifoFlush` for exactly one cycle after the write edge. Bit 4 then reads 1 until a register read clears it, and writing 0 to it leaves it unchanged. Any frame in progress is abandoned: it gets no further writes and no commit.
- R4: While receive enable is 0, the block writes, commits and drops nothing. If enable is cleared while a frame is being written, the cycle after the register update carries a `fifoDrop` pulse.
- R5: With receive enable set, a destination address of FF-FF-FF-FF-FF-FF is accepted, whatever accept-all-multicast holds.
- R6: With promiscuous set, every frame is accepted, whatever its destination address.
- R7: A destination address equal to `stationAddr` is accepted. The first byte on the wire compares with `stationAddr[47:40]` and the sixth with `stationAddr[7:0]`.
- R8: A multicast address (bit 0 of the first byte set) that is neither broadcast nor the station address is accepted only when accept-all-multicast is set.
- R9: Bytes 1 to 5 of a frame are written. On the sixth byte, an accepted frame writes it. A rejected frame instead gives a `fifoDrop` pulse and writes nothing more through its end.
- R10: The last byte of an accepted frame is written together with `fifoCommit`. If the CRC flag is low and reject-bad-CRC is set, that cycle instead carries `fifoFlush` and `rxErr`, with no write and no commit. With reject-bad-CRC clear, a bad-CRC frame is committed normally.
- R11: A frame that ends before its sixth byte produces `fifoDrop` on its last byte. A one-byte frame produces no output at all.
- R12: A start-of-frame strobe inside a frame being written produces `fifoDrop`. Everything up to the next end-of-frame is then discarded.
- R13: Each `fifoWr` appears one cycle after its input byte, and `fifoData` equals that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Control register write strobe |
| regRd | input | 1 | Control register read strobe (clears the flush bit) |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational |
| stationAddr | input | 48 | Station address, first wire byte in bits 47:40 |
| rxValid | input | 1 | Receive byte valid |
| rxSof | input | 1 | First byte of frame |
| rxEof | input | 1 | Last byte of frame |
| rxData | input | 8 | Receive byte |
| rxCrcOk | input | 1 | CRC good, sampled with the last byte |
| fifoWr | output | 1 | FIFO byte write |
| fifoData | output | 8 | FIFO write data |
| fifoCommit | output | 1 | Commit the frame written so far |
| fifoDrop | output | 1 | Discard uncommitted bytes |
| fifoFlush | output | 1 | Reset the whole FIFO |
| rxErr | output | 1 | Bad-CRC error pulse |

## Verification
The hardest situations to reach are the ones where the frame stream and the register bus collide. These include a flush request or an enable change arriving while a frame is half written, and a second start strobe arriving before the first frame has ended. The bench drives these cases directly, cycle by cycle, and interleaves register writes with individual stream bytes. A sweep then crosses all sixteen settings of the four control bits with five address classes, both CRC outcomes and four frame lengths. The lengths are one byte, shorter than the address, exactly the address, and longer than the address. The bench predicts every output of every cycle from the acceptance rules.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int CTRL_W = 5;
  localparam int BIT_EN = 0;
  localparam int BIT_MCAST = 1;
  localparam int BIT_PROMISC = 2;
  localparam int BIT_REJBAD = 3;
  localparam int BIT_FLUSH = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_PASS, ST_SKIP} rxState_e;

  // strobes from control toward the FIFO-side output stage
  typedef struct packed {
    logic wr;
    logic commit;
    logic drop;
    logic flush;
    logic err;
  } fifoStrb_t;

  // address capture commands
  typedef struct packed {
    logic capStart;
    logic capNext;
  } capStrb_t;

  // address classification back to control
  typedef struct packed {
    logic last;
    logic bcast;
    logic mcast;
    logic station;
  } daFlags_t;
endpackage

// File: rtl/rxf_datapath.sv
module rxf_datapath
  import rxf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_BYTES = 6
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [ADDR_BYTES*DATA_W-1:0] stationAddr,
  input  logic [DATA_W-1:0]            rxData,
  input  capStrb_t                     cap,
  input  fifoStrb_t                    strb,
  output daFlags_t                     daFlags,
  output logic                         fifoWr,
  output logic [DATA_W-1:0]            fifoData,
  output logic                         fifoCommit,
  output logic                         fifoDrop,
  output logic                         fifoFlush,
  output logic                         rxErr
);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam int BUF_N = ADDR_BYTES - 1;

  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] daBuf [BUF_N];
  logic [DATA_W-1:0] curBytes [ADDR_BYTES];
  logic [ADDR_BYTES-1:0] isOnes, isMatch;

  generate
    for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_cmp
      if (k < BUF_N) begin : g_held
        assign curBytes[k] = daBuf[k];
      end else begin : g_live
        assign curBytes[k] = rxData;
      end
      assign isOnes[k]  = &curBytes[k];
      assign isMatch[k] = curBytes[k] == stationAddr[(ADDR_BYTES-1-k)*DATA_W +: DATA_W];
    end
  endgenerate

  assign daFlags.last    = cnt == CNT_W'(BUF_N);
  assign daFlags.bcast   = &isOnes;
  assign daFlags.mcast   = curBytes[0][0];
  assign daFlags.station = &isMatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
      for (int k = 0; k < BUF_N; k++) daBuf[k] <= '0;
    end else if (cap.capStart) begin
      daBuf[0] <= rxData;
      cnt <= CNT_W'(1);
    end else if (cap.capNext) begin
      for (int k = 0; k < BUF_N; k++)
        if (cnt == CNT_W'(k)) daBuf[k] <= rxData;
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifoWr <= 1'b0;
      fifoData <= '0;
      fifoCommit <= 1'b0;
      fifoDrop <= 1'b0;
      fifoFlush <= 1'b0;
      rxErr <= 1'b0;
    end else begin
      fifoWr <= strb.wr;
      fifoData <= rxData;
      fifoCommit <= strb.commit;
      fifoDrop <= strb.drop;
      fifoFlush <= strb.flush;
      rxErr <= strb.err;
    end
  end

  // R10: a frame ends in at most one way per cycle
  p_one_ending_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({fifoCommit, fifoDrop, fifoFlush}));
  // R9: the address counter never runs past the address field
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(BUF_N));
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata,
  input  logic             rxValid,
  input  logic             rxSof,
  input  logic             rxEof,
  input  logic             rxCrcOk,
  input  daFlags_t         daFlags,
  output capStrb_t         cap,
  output fifoStrb_t        strb
);
  logic rxEn, allMcast, promisc, rejBad, flushPend;
  logic flushReq, accept;
  logic unusedWdata;
  rxState_e state, nxt;

  assign unusedWdata = ^regWdata[REG_W-1:CTRL_W];
  assign flushReq = regWr && regWdata[BIT_FLUSH];
  assign regRdata = {{(REG_W-CTRL_W){1'b0}}, flushPend, rejBad, promisc, allMcast, rxEn};
  assign accept = promisc || daFlags.bcast || daFlags.station || (daFlags.mcast && allMcast);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxEn <= 1'b0;
      allMcast <= 1'b0;
      promisc <= 1'b0;
      rejBad <= 1'b1;
      flushPend <= 1'b0;
      state <= ST_IDLE;
    end else begin
      if (regWr) begin
        rxEn <= regWdata[BIT_EN];
        allMcast <= regWdata[BIT_MCAST];
        promisc <= regWdata[BIT_PROMISC];
        rejBad <= regWdata[BIT_REJBAD];
      end
      if (flushReq) flushPend <= 1'b1;
      else if (regRd) flushPend <= 1'b0;
      state <= nxt;
    end
  end

  always_comb begin
    nxt = state;
    strb = '0;
    cap = '0;
    if (flushReq) begin
      strb.flush = 1'b1;
      nxt = ST_IDLE;
    end else if (!rxEn) begin
      strb.drop = (state == ST_ADDR) || (state == ST_PASS);
      nxt = ST_IDLE;
    end else if (rxValid) begin
      unique case (state)
        ST_IDLE: if (rxSof && !rxEof) begin
          strb.wr = 1'b1;
          cap.capStart = 1'b1;
          nxt = ST_ADDR;
        end
        ST_ADDR, ST_PASS: begin
          if (rxSof) begin
            strb.drop = 1'b1;
            nxt = rxEof ? ST_IDLE : ST_SKIP;
          end else if (state == ST_ADDR && !daFlags.last) begin
            if (rxEof) begin
              strb.drop = 1'b1;
              nxt = ST_IDLE;
            end else begin
              strb.wr = 1'b1;
              cap.capNext = 1'b1;
            end
          end else if (state == ST_ADDR && !accept) begin
            strb.drop = 1'b1;
            nxt = rxEof ? ST_IDLE : ST_SKIP;
          end else if (rxEof) begin
            if (!rxCrcOk && rejBad) begin
              strb.flush = 1'b1;
              strb.err = 1'b1;
            end else begin
              strb.wr = 1'b1;
              strb.commit = 1'b1;
            end
            nxt = ST_IDLE;
          end else begin
            strb.wr = 1'b1;
            nxt = ST_PASS;
          end
        end
        default: if (rxEof) nxt = ST_IDLE;
      endcase
    end
  end

  // R3: a flush write leaves the flush bit set for software to see
  p_flush_pend_r3: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> flushPend);
  // R10: error only for a bad CRC with rejection on, always with a FIFO reset
  p_err_cause_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.err |-> (strb.flush && rejBad && !rxCrcOk));
  // R4: nothing written or committed while the receiver is off
  p_quiet_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |-> !(strb.wr || strb.commit));
  // R9: a rejected frame stays silent
  p_skip_silent_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP) |-> !(strb.wr || strb.commit || strb.drop));
endmodule

// File: rtl/eth_rx_filter.sv
module eth_rx_filter
  import rxf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_BYTES = 6,
  parameter int REG_W = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         regWr,
  input  logic                         regRd,
  input  logic [REG_W-1:0]             regWdata,
  output logic [REG_W-1:0]             regRdata,
  input  logic [ADDR_BYTES*DATA_W-1:0] stationAddr,
  input  logic                         rxValid,
  input  logic                         rxSof,
  input  logic                         rxEof,
  input  logic [DATA_W-1:0]            rxData,
  input  logic                         rxCrcOk,
  output logic                         fifoWr,
  output logic [DATA_W-1:0]            fifoData,
  output logic                         fifoCommit,
  output logic                         fifoDrop,
  output logic                         fifoFlush,
  output logic                         rxErr
);
  daFlags_t  daFlags;
  capStrb_t  cap;
  fifoStrb_t strb;

  rxf_ctrl #(.REG_W(REG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata),
    .rxValid(rxValid), .rxSof(rxSof), .rxEof(rxEof), .rxCrcOk(rxCrcOk),
    .daFlags(daFlags), .cap(cap), .strb(strb)
  );

  rxf_datapath #(.DATA_W(DATA_W), .ADDR_BYTES(ADDR_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .stationAddr(stationAddr), .rxData(rxData),
    .cap(cap), .strb(strb), .daFlags(daFlags),
    .fifoWr(fifoWr), .fifoData(fifoData), .fifoCommit(fifoCommit),
    .fifoDrop(fifoDrop), .fifoFlush(fifoFlush), .rxErr(rxErr)
  );
endmodule

// File: tb/eth_rx_filter_test.sv
`timescale 1ns/1ps
module eth_rx_filter_test;
  localparam logic [47:0] STATION = 48'h02_11_22_33_44_55;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWr = 0, regRd = 0;
  logic [31:0] regWdata = '0, regRdata;
  logic rxValid = 0, rxSof = 0, rxEof = 0, rxCrcOk = 0;
  logic [7:0] rxData = '0, fifoData;
  logic fifoWr, fifoCommit, fifoDrop, fifoFlush, rxErr;
  int nTests = 0, nFails = 0;

  always #4 clk = ~clk;

  eth_rx_filter uut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regWdata(regWdata),
    .regRdata(regRdata), .stationAddr(STATION), .rxValid(rxValid), .rxSof(rxSof),
    .rxEof(rxEof), .rxData(rxData), .rxCrcOk(rxCrcOk), .fifoWr(fifoWr),
    .fifoData(fifoData), .fifoCommit(fifoCommit), .fifoDrop(fifoDrop),
    .fifoFlush(fifoFlush), .rxErr(rxErr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // outputs packed as {wr, commit, drop, flush, err, data-when-written}
  function automatic logic [31:0] outs();
    return {19'd0, fifoWr, fifoCommit, fifoDrop, fifoFlush, rxErr, fifoWr ? fifoData : 8'h00};
  endfunction

  function automatic logic [31:0] pack(bit w, bit c, bit d, bit f, bit e, logic [7:0] data);
    return {19'd0, w, c, d, f, e, w ? data : 8'h00};
  endfunction

  task automatic regWrite(logic [31:0] v);
    @(negedge clk); regWr = 1; regWdata = v;
    @(posedge clk); #1; regWr = 0;
  endtask

  task automatic regRead(output logic [31:0] v);
    @(negedge clk); regRd = 1; #1; v = regRdata;
    @(posedge clk); #1; regRd = 0;
  endtask

  task automatic driveByte(bit sof, bit eof, logic [7:0] d, bit crc);
    @(negedge clk); rxValid = 1; rxSof = sof; rxEof = eof; rxData = d; rxCrcOk = crc;
    @(posedge clk); #1;
  endtask

  task automatic idleCycle();
    @(negedge clk); rxValid = 0; rxSof = 0; rxEof = 0;
    @(posedge clk); #1;
  endtask

  function automatic logic [47:0] daOf(int kind);
    case (kind)
      0: return STATION;
      1: return 48'hFF_FF_FF_FF_FF_FF;
      2: return 48'h01_00_5E_00_00_07;
      3: return 48'h02_11_22_33_44_56;
      default: return 48'hFF_FF_FF_FF_FF_FE;
    endcase
  endfunction

  function automatic int lenOf(int li);
    case (li)
      0: return 1;
      1: return 4;
      2: return 6;
      default: return 9;
    endcase
  endfunction

  task automatic sendFrame(logic [47:0] da, int n, bit crc, bit en, bit amul, bit prms, bit rej);
    bit acc, bc, st, mc;
    bc = da == 48'hFF_FF_FF_FF_FF_FF;
    st = da == STATION;
    mc = da[40];
    acc = prms || bc || st || (mc && amul);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      bit w, c, dr, f, e;
      string tag;
      d = (i < 6) ? da[47-8*i -: 8] : 8'(8'h30 + i);
      driveByte(i == 0, i == n - 1, d, crc);
      {w, c, dr, f, e} = '0;
      tag = "R13";
      if (!en) tag = "R4";
      else if (n == 1) tag = "R11";
      else if (i < 5) begin
        if (i == n - 1) begin dr = 1; tag = "R11"; end else w = 1;
      end else if (i == 5 && !acc) begin
        dr = 1;
        tag = (mc && !bc) ? "R8" : "R9";
      end else if (acc) begin
        if (i == 5) tag = prms ? "R6" : bc ? "R5" : st ? "R7" : "R8";
        if (i == n - 1) begin
          if (!crc && rej) begin f = 1; e = 1; end else begin w = 1; c = 1; end
          tag = "R10";
        end else w = 1;
      end else tag = "R9";
      chk(tag, outs(), pack(w, c, dr, f, e, d));
    end
    idleCycle();
    chk("R9", outs(), '0);
  endtask

  initial begin
    #(8 * 150000);
    nFails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", nTests + 1, nFails);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    repeat (3) @(posedge clk);
    #1; chk("R1", outs(), '0);
    @(negedge clk); rstN = 1;
    regRead(rv); chk("R1", rv, 32'h8);
    // reserved bits ignore writes, low four bits stored (R1, R2)
    regWrite(32'hFFFF_FFEF); regRead(rv); chk("R2", rv, 32'hF);
    chk("R1", {27'd0, rv[31:27]}, '0);
    regWrite(32'h0000_0005); regRead(rv); chk("R2", rv, 32'h5);

    // R3: flush pulse, sticky until read, zero write has no effect
    regWrite(32'h11); chk("R3", {31'd0, fifoFlush}, 1);
    idleCycle(); chk("R3", {31'd0, fifoFlush}, 0);
    regWrite(32'h01); regRead(rv); chk("R3", rv, 32'h11);
    regRead(rv); chk("R3", rv, 32'h01);

    // R3: flush in the middle of an accepted frame abandons it
    regWrite(32'h05);
    for (int i = 0; i < 3; i++) driveByte(i == 0, 0, 8'(i), 1);
    @(negedge clk); rxValid = 1; rxSof = 0; rxEof = 0; rxData = 8'h77;
    regWr = 1; regWdata = 32'h15;
    @(posedge clk); #1; regWr = 0;
    chk("R3", outs(), pack(0, 0, 0, 1, 0, 0));
    for (int i = 4; i < 8; i++) begin
      driveByte(0, i == 7, 8'(i), 1);
      chk("R3", outs(), '0);
    end
    regRead(rv);

    // R4: enable cleared while writing gives a drop
    for (int i = 0; i < 3; i++) driveByte(i == 0, 0, 8'(i), 1);
    idleCycle();
    regWrite(32'h04);
    chk("R4", outs(), '0);
    idleCycle(); chk("R4", outs(), pack(0, 0, 1, 0, 0, 0));
    driveByte(0, 1, 8'h00, 1); chk("R4", outs(), '0);

    // R12: second start strobe inside a frame
    regWrite(32'h05);
    for (int i = 0; i < 7; i++) driveByte(i == 0, 0, 8'(i), 1);
    driveByte(1, 0, 8'hAA, 1); chk("R12", outs(), pack(0, 0, 1, 0, 0, 0));
    driveByte(0, 0, 8'hBB, 1); chk("R12", outs(), '0);
    driveByte(0, 1, 8'hCC, 1); chk("R12", outs(), '0);
    sendFrame(STATION, 9, 1, 1, 0, 1, 1);

    // sweep: all control settings, address classes, CRC outcomes, lengths
    for (int cfgv = 0; cfgv < 16; cfgv++) begin
      regWrite(32'(cfgv));
      for (int kind = 0; kind < 5; kind++)
        for (int ci = 0; ci < 2; ci++)
          for (int li = 0; li < 4; li++)
            sendFrame(daOf(kind), lenOf(li), ci == 1,
                      cfgv[0], cfgv[1], cfgv[2], cfgv[3]);
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule